// File: doc/BRIEF.md
# Multithreaded Stack File

This block is the operand store of a small barrel-threaded processor. Every hardware thread owns four independent last-in first-out stacks of 32-bit words, and all of them live in inferred block RAM. Each access supplies a thread number, two source stack selectors and one destination selector. It also supplies separate flags that say whether each source is popped and whether the write data is pushed. A source stack is only looked at unless its pop flag is raised, so a loop index or an address can be used again and again without being copied.

The two source tops come back one clock after the access, as they would from a registered RAM. Pointer movement is fully explicit. A pop and a push on the same stack in one access overwrite the top in place. Popping an empty stack or pushing onto a full one is refused and recorded in a sticky per-thread error bit. The processor owns the thread rotation; this block serves whichever thread is presented in each cycle.

Top module: `tstk_file`

## Requirements
- R1: After a synchronous reset, every stack of every thread is empty, both top outputs read zero and all error bits are zero.
- R2: The tops of the stacks chosen by `sel_a` and `sel_b` for thread `thr_id` appear on `top_a` and `top_b` right after the rising edge that samples the access. The top is the newest entry that has not been popped; an empty stack reads as zero.
- R3: A source whose pop flag is low keeps its depth, so repeated reads return the same value.
- R4: With `push` high, `push_data` becomes the new top of stack `sel_d` of that thread. The stack holds up to 32 entries.
- R5: `pop_a` or `pop_b` removes the top of its selected stack, and that access still reports the removed value as its operand.
- R6: When `sel_a` equals `sel_b`, both outputs show the same value. If both pop flags are set as well, only one entry is removed.
- R7: A pop and a push aimed at the same stack replace the top in place. The depth is unchanged and the outputs show the old top.
- R8: Popping an empty stack, or pushing onto a stack that already holds 32 entries, changes neither that stack's depth nor its contents. It sets bit `thr_id` of `err_thr`, and that bit stays set until reset. Other stacks touched in the same access still move.
- R9: An access by one thread changes neither the stacks nor the error bit of any other thread.
- R10: While `acc_en` is low, no stack changes, whatever the other inputs are, and both outputs and the error bits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Access valid in this cycle |
| thr_id | input | 3 | Thread issuing the access |
| sel_a | input | 2 | First source stack |
| sel_b | input | 2 | Second source stack |
| sel_d | input | 2 | Destination stack |
| pop_a | input | 1 | Pop first source |
| pop_b | input | 1 | Pop second source |
| push | input | 1 | Push `push_data` onto destination |
| push_data | input | 32 | Value to push |
| top_a | output | 32 | Top of first source, one clock after the access |
| top_b | output | 32 | Top of second source, one clock after the access |
| err_thr | output | 8 | Sticky error bit per thread |

## Verification
Directed runs separate a non-destructive read from a pop, because repeated reads without pops must keep returning the same word. Selecting the same stack on both sides with both pop flags set tells a single pop from a double one. A pop and a push on the same stack tell replace-top from a plain push. Filling one stack to 32 entries and draining another past empty exercise both refusal paths and the sticky error bit. A long mixed run then interleaves threads, idle cycles and every flag combination against a queue-based model, and catches any leakage between threads or any wrong pointer arithmetic.

// File: rtl/tstk_pkg.sv
package tstk_pkg;
   // Pointer movement of one stack in one access, coded as {push, pop}
   typedef enum logic [1:0] {
      MV_HOLD = 2'b00,
      MV_POP  = 2'b01,
      MV_PUSH = 2'b10,
      MV_REPL = 2'b11
   } mv_e;
endpackage

// File: rtl/tstk_ram.sv
module tstk_ram #(
   parameter int DW = 32,
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata
);
   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem [WORDS];

   // Read returns the old word when the same address is written in this cycle
   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
      if (we) mem[waddr] <= wdata;
   end
endmodule

// File: rtl/tstk_ptr_bank.sv
module tstk_ptr_bank
   import tstk_pkg::*;
#(
   parameter int N_THR = 8,
   parameter int N_STK = 4,
   parameter int DEPTH = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     acc_en,
   input  logic [$clog2(N_THR)-1:0] thr_id,
   input  logic [$clog2(N_STK)-1:0] sel_a,
   input  logic [$clog2(N_STK)-1:0] sel_b,
   input  logic [$clog2(N_STK)-1:0] sel_d,
   input  logic                     pop_a,
   input  logic                     pop_b,
   input  logic                     push,
   output logic [$clog2(DEPTH)-1:0] top_idx_a,
   output logic [$clog2(DEPTH)-1:0] top_idx_b,
   output logic                     empty_a,
   output logic                     empty_b,
   output logic                     wr_en,
   output logic [$clog2(DEPTH)-1:0] wr_idx,
   output logic [N_THR-1:0]         err_q
);
   localparam int TW    = $clog2(N_THR);
   localparam int SW    = $clog2(N_STK);
   localparam int IW    = $clog2(DEPTH);
   localparam int PW    = IW + 1;
   localparam int SLOTS = N_THR * N_STK;

   logic [PW-1:0]    ptr_q [SLOTS];
   logic [PW-1:0]    cur   [N_STK];
   logic [PW-1:0]    nxt   [N_STK];
   logic [N_STK-1:0] pop_v, push_v, bad_v;
   mv_e              mv    [N_STK];

   always_comb begin
      for (int s = 0; s < N_STK; s++) begin
         cur[s]    = ptr_q[{thr_id, SW'(s)}];
         pop_v[s]  = (pop_a && (sel_a == SW'(s))) || (pop_b && (sel_b == SW'(s)));
         push_v[s] = push && (sel_d == SW'(s));
         mv[s]     = mv_e'({push_v[s], pop_v[s]});
         bad_v[s]  = (pop_v[s] && (cur[s] == '0)) ||
                     (push_v[s] && !pop_v[s] && (cur[s] == PW'(DEPTH)));
         nxt[s]    = cur[s];
         if (!bad_v[s]) begin
            unique case (mv[s])
               MV_POP:  nxt[s] = cur[s] - PW'(1);
               MV_PUSH: nxt[s] = cur[s] + PW'(1);
               default: nxt[s] = cur[s];
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < SLOTS; i++) ptr_q[i] <= '0;
      end else if (acc_en) begin
         for (int s = 0; s < N_STK; s++) ptr_q[{thr_id, SW'(s)}] <= nxt[s];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                  err_q <= '0;
      else if (acc_en && |bad_v) err_q[thr_id] <= 1'b1;
   end

   logic [PW-1:0] cur_a, cur_b, cur_d;
   assign cur_a     = cur[sel_a];
   assign cur_b     = cur[sel_b];
   assign cur_d     = cur[sel_d];
   assign top_idx_a = IW'(cur_a - PW'(1));
   assign top_idx_b = IW'(cur_b - PW'(1));
   assign empty_a   = (cur_a == '0);
   assign empty_b   = (cur_b == '0);
   assign wr_en     = acc_en && push && !bad_v[sel_d];
   assign wr_idx    = pop_v[sel_d] ? IW'(cur_d - PW'(1)) : IW'(cur_d);

   logic unused_tw;
   assign unused_tw = ^TW;
endmodule

// File: rtl/tstk_file.sv
module tstk_file #(
   parameter int DATA_W = 32,
   parameter int N_THR  = 8,
   parameter int N_STK  = 4,
   parameter int DEPTH  = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     acc_en,
   input  logic [$clog2(N_THR)-1:0] thr_id,
   input  logic [$clog2(N_STK)-1:0] sel_a,
   input  logic [$clog2(N_STK)-1:0] sel_b,
   input  logic [$clog2(N_STK)-1:0] sel_d,
   input  logic                     pop_a,
   input  logic                     pop_b,
   input  logic                     push,
   input  logic [DATA_W-1:0]        push_data,
   output logic [DATA_W-1:0]        top_a,
   output logic [DATA_W-1:0]        top_b,
   output logic [N_THR-1:0]         err_thr
);
   localparam int TW = $clog2(N_THR);
   localparam int SW = $clog2(N_STK);
   localparam int IW = $clog2(DEPTH);
   localparam int AW = TW + SW + IW;
   localparam int NPORT = 2;

   if (N_THR < 2 || (N_THR & (N_THR - 1)) != 0) begin : g_bad_thr
      $error("N_THR must be a power of two, at least 2");
   end
   if (N_STK < 2 || (N_STK & (N_STK - 1)) != 0) begin : g_bad_stk
      $error("N_STK must be a power of two, at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [IW-1:0] top_idx_a, top_idx_b, wr_idx;
   logic          empty_a, empty_b, wr_en;

   tstk_ptr_bank #(.N_THR(N_THR), .N_STK(N_STK), .DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst(rst), .acc_en(acc_en), .thr_id(thr_id),
      .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d),
      .pop_a(pop_a), .pop_b(pop_b), .push(push),
      .top_idx_a(top_idx_a), .top_idx_b(top_idx_b),
      .empty_a(empty_a), .empty_b(empty_b),
      .wr_en(wr_en), .wr_idx(wr_idx), .err_q(err_thr)
   );

   logic [AW-1:0]     waddr;
   logic [AW-1:0]     raddr  [NPORT];
   logic              empty  [NPORT];
   logic              emp_q  [NPORT];
   logic [DATA_W-1:0] rdata  [NPORT];
   logic [DATA_W-1:0] top_o  [NPORT];

   assign waddr = {thr_id, sel_d, wr_idx};

   // One RAM copy per read port; both copies take every write
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      if (p == 0) begin : g_first
         assign raddr[p] = {thr_id, sel_a, top_idx_a};
         assign empty[p] = empty_a;
      end else begin : g_second
         assign raddr[p] = {thr_id, sel_b, top_idx_b};
         assign empty[p] = empty_b;
      end

      tstk_ram #(.DW(DATA_W), .AW(AW)) u_ram (
         .clk(clk), .re(acc_en), .raddr(raddr[p]), .rdata(rdata[p]),
         .we(wr_en), .waddr(waddr), .wdata(push_data)
      );

      always_ff @(posedge clk) begin
         if (rst)         emp_q[p] <= 1'b1;
         else if (acc_en) emp_q[p] <= empty[p];
      end

      assign top_o[p] = emp_q[p] ? '0 : rdata[p];
   end

   assign top_a = top_o[0];
   assign top_b = top_o[1];
endmodule

// File: rtl/tstk_file_chk.sv
module tstk_file_chk #(
   parameter int DATA_W = 32,
   parameter int N_THR  = 8,
   parameter int N_STK  = 4
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     acc_en,
   input logic [$clog2(N_THR)-1:0] thr_id,
   input logic [$clog2(N_STK)-1:0] sel_a,
   input logic [$clog2(N_STK)-1:0] sel_b,
   input logic [DATA_W-1:0]        top_a,
   input logic [DATA_W-1:0]        top_b,
   input logic [N_THR-1:0]         err_thr
);
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (err_thr == '0 && top_a == '0 && top_b == '0));

   a_r6_same_top: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(acc_en) && $past(sel_a) == $past(sel_b)) |-> (top_a == top_b));

   a_r8_sticky_err: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((err_thr & $past(err_thr)) == $past(err_thr)));

   a_r9_err_own_thread: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(acc_en)) |->
         (((err_thr ^ $past(err_thr)) & ~(N_THR'(1) << $past(thr_id))) == '0));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(acc_en)) |->
         ($stable(top_a) && $stable(top_b) && $stable(err_thr)));
endmodule

bind tstk_file tstk_file_chk #(.DATA_W(DATA_W), .N_THR(N_THR), .N_STK(N_STK)) u_chk (
   .clk(clk), .rst(rst), .acc_en(acc_en), .thr_id(thr_id),
   .sel_a(sel_a), .sel_b(sel_b), .top_a(top_a), .top_b(top_b), .err_thr(err_thr)
);

// File: tb/test_tstk_file.sv
module test_tstk_file;
   localparam int DW = 32, NT = 8, NS = 4, DEP = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          acc_en = 1'b0;
   logic [2:0]    thr_id = '0;
   logic [1:0]    sel_a = '0, sel_b = '0, sel_d = '0;
   logic          pop_a = 1'b0, pop_b = 1'b0, push = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic [DW-1:0] top_a, top_b;
   logic [NT-1:0] err_thr;

   always #4 clk = ~clk;

   tstk_file #(.DATA_W(DW), .N_THR(NT), .N_STK(NS), .DEPTH(DEP)) i_tstk_file (
      .clk(clk), .rst(rst), .acc_en(acc_en), .thr_id(thr_id),
      .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d),
      .pop_a(pop_a), .pop_b(pop_b), .push(push), .push_data(push_data),
      .top_a(top_a), .top_b(top_b), .err_thr(err_thr)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // Reference: one queue per (thread, stack), back of queue is the top
   logic [DW-1:0] mq [NT*NS][$];
   logic [DW-1:0] exp_a = '0, exp_b = '0;
   logic [NT-1:0] exp_err = '0;

   task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] model_top(int t, int s);
      int idx = t*NS + s;
      if (mq[idx].size() == 0) return '0;
      return mq[idx][mq[idx].size()-1];
   endfunction

   task automatic step(string tag, bit en, int t, int sa, int sb, int sd,
                       bit pa, bit pb, bit ps, logic [DW-1:0] wd);
      if (en) begin
         exp_a = model_top(t, sa);
         exp_b = model_top(t, sb);
         for (int s = 0; s < NS; s++) begin
            int  idx   = t*NS + s;
            bit  popx  = (pa && sa == s) || (pb && sb == s);
            bit  pushx = ps && sd == s;
            if (popx && mq[idx].size() == 0) exp_err[t] = 1'b1;
            else if (pushx && !popx && mq[idx].size() == DEP) exp_err[t] = 1'b1;
            else begin
               if (popx)  void'(mq[idx].pop_back());
               if (pushx) mq[idx].push_back(wd);
            end
         end
      end
      acc_en = en; thr_id = 3'(t); sel_a = 2'(sa); sel_b = 2'(sb); sel_d = 2'(sd);
      pop_a = pa; pop_b = pb; push = ps; push_data = wd;
      @(posedge clk);
      #2;
      check(tag, "top_a", top_a, exp_a);
      check(tag, "top_b", top_b, exp_b);
      check(tag, "err_thr", DW'(err_thr), DW'(exp_err));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst = 1'b0;
      // R1: reset state
      check("R1", "top_a", top_a, '0);
      check("R1", "top_b", top_b, '0);
      check("R1", "err_thr", DW'(err_thr), '0);

      // R4: pushes onto thread 0 stack 0, R2 latency on each
      step("R4", 1, 0, 0, 0, 0, 0, 0, 1, 32'h10);
      step("R4", 1, 0, 0, 0, 0, 0, 0, 1, 32'h20);
      step("R4", 1, 0, 0, 0, 0, 0, 0, 1, 32'h30);
      step("R2", 1, 0, 0, 1, 1, 0, 0, 1, 32'h77);
      // R3: repeated reads, no pop
      step("R3", 1, 0, 0, 1, 2, 0, 0, 0, '0);
      step("R3", 1, 0, 0, 1, 2, 0, 0, 0, '0);
      // R5: pop returns the removed value, next read shows the one below
      step("R5", 1, 0, 0, 1, 2, 1, 0, 0, '0);
      step("R5", 1, 0, 0, 1, 2, 0, 1, 0, '0);
      step("R5", 1, 0, 0, 1, 2, 0, 0, 0, '0);
      // R6: same stack both sides, both pops remove one entry
      step("R6", 1, 0, 0, 0, 3, 1, 1, 0, '0);
      step("R6", 1, 0, 0, 0, 3, 0, 0, 0, '0);
      // R7: replace top in place
      step("R7", 1, 0, 2, 2, 2, 0, 0, 1, 32'hA1);
      step("R7", 1, 0, 2, 2, 2, 0, 0, 1, 32'hA2);
      step("R7", 1, 0, 2, 1, 2, 1, 0, 1, 32'hB7);
      step("R7", 1, 0, 2, 2, 3, 0, 0, 0, '0);
      step("R7", 1, 0, 2, 2, 3, 1, 0, 0, '0);
      step("R7", 1, 0, 2, 2, 3, 0, 0, 0, '0);
      // R8: pop of empty stack on thread 2, sticky bit 2
      step("R8", 1, 2, 1, 3, 0, 1, 0, 1, 32'h55);
      step("R8", 1, 2, 0, 1, 3, 0, 0, 0, '0);
      step("R8", 1, 2, 0, 0, 3, 1, 0, 0, '0);
      step("R8", 1, 2, 0, 0, 3, 0, 0, 0, '0);
      // R8: fill thread 5 stack 3, the 33rd push is refused
      for (int i = 0; i < DEP; i++) step("R8", 1, 5, 3, 0, 3, 0, 0, 1, 32'h100 + i);
      step("R8", 1, 5, 3, 3, 3, 0, 0, 1, 32'hDEAD);
      step("R8", 1, 5, 3, 3, 3, 0, 0, 0, '0);
      // R9: another thread, same selectors, distinct data
      step("R9", 1, 1, 0, 0, 0, 0, 0, 1, 32'hC0);
      step("R9", 1, 0, 0, 1, 0, 0, 0, 0, '0);
      step("R9", 1, 1, 0, 3, 0, 0, 0, 0, '0);
      step("R9", 1, 5, 3, 0, 0, 0, 0, 0, '0);
      // R10: idle cycles with flags raised change nothing
      step("R10", 0, 1, 0, 0, 0, 1, 1, 1, 32'hBAD);
      step("R10", 0, 0, 1, 2, 1, 1, 0, 1, 32'hBAD);
      step("R10", 1, 1, 0, 0, 0, 0, 0, 0, '0);
      step("R10", 1, 0, 1, 0, 0, 0, 0, 0, '0);

      // Mixed run over all threads against the model
      for (int k = 0; k < 4000; k++) begin
         int r = $urandom;
         step("R9", (r % 7) != 0, (r >> 3) % NT, (r >> 6) % NS, (r >> 8) % NS,
              (r >> 10) % NS, ((r >> 12) % 4) == 0, ((r >> 14) % 5) == 0,
              ((r >> 17) % 2) == 0, $urandom);
      end

      // R1: reset again clears everything
      rst = 1'b1; acc_en = 1'b0;
      repeat (2) @(posedge clk);
      #2 rst = 1'b0;
      for (int i = 0; i < NT*NS; i++) mq[i].delete();
      exp_err = '0; exp_a = '0; exp_b = '0;
      check("R1", "err_thr", DW'(err_thr), '0);
      step("R1", 1, 5, 3, 0, 0, 0, 0, 0, '0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule